// File: doc/BRIEF.md
# Time-Interleaved ADC Timing-Skew Background Calibrator

This block removes sampling-instant mismatch from the merged output of a four-way time-interleaved converter. Samples arrive one per clock, as 8-bit two's-complement values with a valid strobe, and belong to the sub-converters in strict rotation. The block identifies each sample's channel from the rotation itself. It learns a timing-skew estimate for every channel except the first without any calibration tone or spare channel. Each estimate is driven by a least-mean-square loop that compares the products of a sample with its successor and with its predecessor.

Each sample is then corrected to first order. The block subtracts its channel's skew estimate times a local slope. The slope comes from a five-tap central difference over the two neighbours on each side. The result is rounded and clipped back to 8 bits. A freeze input stops adaptation while correction continues, and a shift control sets the loop step size.

Top module: `skew_cal_tiadc`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears out_valid, out_sample, every skew estimate and the channel rotation, so the first valid sample after reset belongs to channel 0.
- R2: The channel index advances by one (modulo 4) only on a clock edge where in_valid is high; cycles with in_valid low, whatever in_sample holds, change neither the rotation, the sample window nor the outputs.
- R3: Once five samples have been accepted since reset, each accepted sample x[n+2] produces exactly one output for x[n]: out_valid is high for one cycle, registered on the clock edge that follows the edge that accepted x[n+2]; out_valid is low otherwise.
- R4: With D = x[n-2] - 8*x[n-1] + 8*x[n+1] - x[n+2] and s the centre channel's skew (signed, 14 fraction bits) before this update, out_sample = clip8(floor((x[n]*2^30 - s*D*5461 + 2^29) / 2^30)), where 5461 approximates 2^16/12.
- R5: Channel 0 is the timing reference, so its skew is always zero and its samples leave the block unchanged.
- R6: For a centre sample of channel k in 1..3, the estimate updates on the output edge: err = x[n]*x[n+1] - x[n-1]*x[n], skew_k += floor(err / 2^m).
- R7: m equals mu_shift for mu_shift 4 to 15; mu_shift values 0 to 3 act as 4.
- R8: Each skew estimate saturates at +32767 and -32768 instead of wrapping.
- R9: out_sample saturates at +127 and -128 when the corrected value leaves the 8-bit range.
- R10: While freeze is high at an update edge, no skew estimate changes, and correction continues with the held values.
- R11: skew_bus carries channel 1 in bits [15:0], channel 2 in [31:16] and channel 3 in [47:32], each as signed two's complement.
- R12: A skew estimate changes only on an edge that also raises out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the aggregate sample rate |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 8 | Interleaved sample, signed |
| freeze | input | 1 | Hold all skew estimates |
| mu_shift | input | 4 | LMS step exponent (step = 2^-mu_shift) |
| out_valid | output | 1 | Corrected sample strobe |
| out_sample | output | 8 | Corrected sample, signed |
| skew_bus | output | 48 | Skew estimates of channels 1 to 3 |

## Verification
The bench steers the estimates into both saturation limits with a periodic pattern that gives one channel persistently positive error and another persistently negative error. A design that wraps would flip the sign of the estimate there. A second pattern with saturated estimates pushes the corrected value past both ends of the 8-bit range, which exposes a missing output clip or a rounding that is off by one. Gaps in the valid strobe carrying junk data would catch a rotation or window that advances on idle cycles, and that fault would shift every later correction onto the wrong channel. Runs with freeze high and with step exponents below the floor check that the estimates hold and that the step is clamped. A mid-stream reset checks that the rotation realigns to channel 0.

// File: rtl/skcal_pkg.sv
`timescale 1ns/1ps
package skcal_pkg;
   // number of samples held for the five-point slope window
   localparam int unsigned WIN_TAPS = 5;

   // nearest integer to 2^sh / 12, used in place of a divider
   function automatic int unsigned recip_twelfth(int unsigned sh);
      return ((32'd1 << sh) + 32'd6) / 32'd12;
   endfunction
endpackage

// File: rtl/skcal_window.sv
`timescale 1ns/1ps
module skcal_window #(
   parameter int DW  = 8,
   parameter int NCH = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic [DW-1:0]            in_sample,
   output logic [4:0][DW-1:0]       tap_q,
   output logic [$clog2(NCH)-1:0]   ctr_tag,
   output logic                     fresh
);
   localparam int CW = $clog2(NCH);
   localparam int FW = $clog2(skcal_pkg::WIN_TAPS + 1);
   localparam logic [FW-1:0] FULL = FW'(skcal_pkg::WIN_TAPS);

   logic [CW-1:0]      ch_cnt;
   logic [2:0][CW-1:0] tag_q;
   logic [FW-1:0]      fill;

   always_ff @(posedge clk) begin
      if (rst) begin
         ch_cnt <= '0;
         fill   <= '0;
         fresh  <= 1'b0;
         tap_q  <= '0;
         tag_q  <= '0;
      end else begin
         fresh <= in_valid && (fill >= FULL - FW'(1));
         if (in_valid) begin
            tap_q  <= {tap_q[3:0], in_sample};
            tag_q  <= {tag_q[1:0], ch_cnt};
            ch_cnt <= ch_cnt + CW'(1);
            if (fill != FULL)
               fill <= fill + FW'(1);
         end
      end
   end

   assign ctr_tag = tag_q[2];
endmodule

// File: rtl/skcal_lms.sv
`timescale 1ns/1ps
module skcal_lms #(
   parameter int DW     = 8,
   parameter int NCH    = 4,
   parameter int SW     = 16,
   parameter int MU_W   = 4,
   parameter int MU_MIN = 4
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      fresh,
   input  logic                      freeze,
   input  logic [MU_W-1:0]           mu_shift,
   input  logic [DW-1:0]             x_prev,
   input  logic [DW-1:0]             x_ctr,
   input  logic [DW-1:0]             x_next,
   input  logic [$clog2(NCH)-1:0]    ctr_tag,
   output logic [(NCH-1)*SW-1:0]     skew_bus,
   output logic signed [SW-1:0]      cur_skew
);
   localparam int CW   = $clog2(NCH);
   localparam int PRW  = 2 * DW;
   localparam int EW   = PRW + 1;
   localparam int SUMW = ((SW > EW) ? SW : EW) + 1;
   localparam logic [MU_W-1:0]        MU_LO = MU_W'(MU_MIN);
   localparam logic signed [SUMW-1:0] SK_HI = SUMW'(2 ** (SW - 1) - 1);
   localparam logic signed [SUMW-1:0] SK_LO = SUMW'(-(2 ** (SW - 1)));

   logic signed [PRW-1:0] p_fwd, p_bwd;
   logic signed [EW-1:0]  err, delta;
   logic [MU_W-1:0]       mu_eff;
   logic signed [SW-1:0]  skew_arr [NCH];

   always_comb begin
      p_fwd  = PRW'($signed(x_ctr)) * PRW'($signed(x_next));
      p_bwd  = PRW'($signed(x_prev)) * PRW'($signed(x_ctr));
      err    = EW'(p_fwd) - EW'(p_bwd);
      mu_eff = (mu_shift < MU_LO) ? MU_LO : mu_shift;
      delta  = err >>> mu_eff;
   end

   assign skew_arr[0] = '0;

   for (genvar k = 1; k < NCH; k++) begin : g_chan
      logic signed [SW-1:0]   sk_q;
      logic signed [SUMW-1:0] sum;
      logic                   upd;

      always_comb begin
         sum = SUMW'(sk_q) + SUMW'(delta);
         upd = fresh && !freeze && (ctr_tag == CW'(k));
      end

      always_ff @(posedge clk) begin
         if (rst)
            sk_q <= '0;
         else if (upd)
            sk_q <= (sum > SK_HI) ? SW'(SK_HI) :
                    (sum < SK_LO) ? SW'(SK_LO) : SW'(sum);
      end

      assign skew_arr[k] = sk_q;
      assign skew_bus[(k-1)*SW +: SW] = sk_q;
   end

   assign cur_skew = skew_arr[ctr_tag];
endmodule

// File: rtl/skcal_comp.sv
`timescale 1ns/1ps
module skcal_comp #(
   parameter int DW    = 8,
   parameter int SW    = 16,
   parameter int SFRAC = 14,
   parameter int RSH   = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 fresh,
   input  logic [4:0][DW-1:0]   taps,
   input  logic signed [SW-1:0] cur_skew,
   output logic                 out_valid,
   output logic [DW-1:0]        out_sample
);
   localparam int DERW  = DW + 6;
   localparam int RCW   = RSH;
   localparam int SH    = SFRAC + RSH;
   localparam int PW    = SW + DERW + RCW;
   localparam int AW0   = PW + 2;
   localparam int AW    = (AW0 > DW + SH + 2) ? AW0 : DW + SH + 2;
   localparam int unsigned RECIP = skcal_pkg::recip_twelfth(RSH);
   localparam logic signed [RCW-1:0] RECIP_S = RCW'(RECIP);
   localparam logic signed [AW-1:0]  HALF    = AW'(1) <<< (SH - 1);
   localparam logic signed [AW-1:0]  TOP     = AW'(2 ** (DW - 1)) <<< SH;
   localparam logic signed [AW-1:0]  BOT     = -TOP;

   logic signed [DERW-1:0] e0, e1, e3, e4, deriv;
   logic signed [PW-1:0]   prod;
   logic signed [AW-1:0]   acc;
   logic [DW-1:0]          res;

   always_comb begin
      e0    = DERW'($signed(taps[0]));
      e1    = DERW'($signed(taps[1]));
      e3    = DERW'($signed(taps[3]));
      e4    = DERW'($signed(taps[4]));
      deriv = e4 - (e3 <<< 3) + (e1 <<< 3) - e0;
      prod  = PW'(cur_skew) * PW'(deriv) * PW'(RECIP_S);
      acc   = (AW'($signed(taps[2])) <<< SH) - AW'(prod) + HALF;
      if (acc >= TOP)
         res = {1'b0, {(DW-1){1'b1}}};
      else if (acc < BOT)
         res = {1'b1, {(DW-1){1'b0}}};
      else
         res = acc[SH+DW-1:SH];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= fresh;
         if (fresh)
            out_sample <= res;
      end
   end
endmodule

// File: rtl/skew_cal_tiadc.sv
`timescale 1ns/1ps
module skew_cal_tiadc #(
   parameter int DATA_W    = 8,
   parameter int NUM_CH    = 4,
   parameter int SKEW_W    = 16,
   parameter int SKEW_FRAC = 14,
   parameter int RECIP_SH  = 16,
   parameter int MU_W      = 4,
   parameter int MU_MIN    = 4
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           in_valid,
   input  logic [DATA_W-1:0]              in_sample,
   input  logic                           freeze,
   input  logic [MU_W-1:0]                mu_shift,
   output logic                           out_valid,
   output logic [DATA_W-1:0]              out_sample,
   output logic [(NUM_CH-1)*SKEW_W-1:0]   skew_bus
);
   localparam int CW = $clog2(NUM_CH);

   if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_nch
      $error("NUM_CH must be a power of two, at least 2");
   end
   if (SKEW_FRAC >= SKEW_W) begin : g_bad_frac
      $error("SKEW_FRAC must be below SKEW_W");
   end
   if (MU_MIN >= 2 ** MU_W) begin : g_bad_mu
      $error("MU_MIN must fit in MU_W bits");
   end
   if (RECIP_SH < 4) begin : g_bad_rsh
      $error("RECIP_SH too small for the reciprocal of 12");
   end

   logic [4:0][DATA_W-1:0] taps;
   logic [CW-1:0]          ctr_tag;
   logic                   fresh;
   logic signed [SKEW_W-1:0] cur_skew;

   skcal_window #(.DW(DATA_W), .NCH(NUM_CH)) u_win (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .tap_q(taps), .ctr_tag(ctr_tag), .fresh(fresh)
   );

   skcal_lms #(.DW(DATA_W), .NCH(NUM_CH), .SW(SKEW_W), .MU_W(MU_W),
               .MU_MIN(MU_MIN)) u_lms (
      .clk(clk), .rst(rst), .fresh(fresh), .freeze(freeze),
      .mu_shift(mu_shift), .x_prev(taps[3]), .x_ctr(taps[2]),
      .x_next(taps[1]), .ctr_tag(ctr_tag), .skew_bus(skew_bus),
      .cur_skew(cur_skew)
   );

   skcal_comp #(.DW(DATA_W), .SW(SKEW_W), .SFRAC(SKEW_FRAC),
                .RSH(RECIP_SH)) u_comp (
      .clk(clk), .rst(rst), .fresh(fresh), .taps(taps),
      .cur_skew(cur_skew), .out_valid(out_valid), .out_sample(out_sample)
   );
endmodule

// File: rtl/skcal_chk.sv
`timescale 1ns/1ps
module skcal_chk #(
   parameter int NUM_CH = 4,
   parameter int SKEW_W = 16
) (
   input logic                         clk,
   input logic                         rst,
   input logic                         in_valid,
   input logic                         freeze,
   input logic                         out_valid,
   input logic [(NUM_CH-1)*SKEW_W-1:0] skew_bus
);
   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> (!out_valid && skew_bus == '0));

   assert_output_follows_input_R3: assert property (@(posedge clk)
      disable iff (rst) out_valid |-> $past(in_valid, 2));

   assert_freeze_holds_R10: assert property (@(posedge clk)
      disable iff (rst) freeze |=> $stable(skew_bus));

   assert_update_with_output_R12: assert property (@(posedge clk)
      disable iff (rst) (!$stable(skew_bus) && !$past(rst)) |-> out_valid);
endmodule

bind skew_cal_tiadc skcal_chk #(.NUM_CH(NUM_CH), .SKEW_W(SKEW_W)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .freeze(freeze),
   .out_valid(out_valid), .skew_bus(skew_bus)
);

// File: tb/skew_cal_tiadc_tb.sv
`timescale 1ns/1ps
module skew_cal_tiadc_tb;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [7:0]  in_sample;
   logic        freeze;
   logic [3:0]  mu_shift;
   logic        out_valid;
   logic [7:0]  out_sample;
   logic [47:0] skew_bus;

   always #2.5 clk = ~clk;

   skew_cal_tiadc u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .freeze(freeze), .mu_shift(mu_shift), .out_valid(out_valid),
      .out_sample(out_sample), .skew_bus(skew_bus)
   );

   int n_chk = 0, n_fail = 0, clip_seen = 0, gidx = 0;
   string req_out = "R4", req_sk = "R6";

   // behavioural reference state
   int  win[5], tags[5], sk[4];
   int  fill, cnt, exp_out;
   bit  fresh_m, exp_valid, exp_clip, exp_c0, started;

   task automatic check(bit ok, string req, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint clampl(longint v, longint lo, longint hi);
      return (v > hi) ? hi : (v < lo) ? lo : v;
   endfunction

   always @(posedge clk) begin
      started <= 1'b1;
      if (rst) begin
         foreach (win[i]) begin win[i] = 0; tags[i] = 0; end
         foreach (sk[i]) sk[i] = 0;
         fill = 0; cnt = 0; fresh_m = 0; exp_valid = 0; exp_out = 0;
      end else begin
         exp_valid = fresh_m;
         if (fresh_m) begin
            longint d, num, q;
            d   = win[4] - 8 * win[3] + 8 * win[1] - win[0];
            num = (longint'(win[2]) <<< 30) - longint'(sk[tags[2]]) * d * 5461
                  + (longint'(1) <<< 29);
            q   = num >>> 30;
            exp_clip = (q > 127) || (q < -128);
            exp_out  = int'(clampl(q, -128, 127));
            exp_c0   = (tags[2] == 0);
            if (tags[2] != 0 && !freeze) begin
               int err, m;
               err = win[2] * win[1] - win[3] * win[2];
               m   = (mu_shift < 4) ? 4 : int'(mu_shift);
               sk[tags[2]] = int'(clampl(longint'(sk[tags[2]]) + (err >>> m),
                                         -32768, 32767));
            end
         end
         fresh_m = in_valid && (fill >= 4);
         if (in_valid) begin
            for (int i = 4; i > 0; i--) begin
               win[i] = win[i-1]; tags[i] = tags[i-1];
            end
            win[0]  = int'($signed(in_sample));
            tags[0] = cnt;
            cnt     = (cnt + 1) % 4;
            if (fill < 5) fill++;
         end
      end
   end

   // compare against the reference on every cycle, away from the edge
   always @(negedge clk) begin
      if (started) begin
         check(out_valid === exp_valid, "R3", out_valid, exp_valid);
         if (exp_valid) begin
            if (exp_clip) clip_seen++;
            check($signed(out_sample) == exp_out,
                  exp_clip ? "R9" : (exp_c0 ? "R5" : req_out),
                  $signed(out_sample), exp_out);
         end
         for (int k = 1; k < 4; k++)
            check($signed(skew_bus[(k-1)*16 +: 16]) == sk[k], req_sk,
                  $signed(skew_bus[(k-1)*16 +: 16]), sk[k]);
      end
   end

   task automatic cyc(bit r, bit v, int s);
      @(negedge clk);
      rst = r; in_valid = v; in_sample = s[7:0];
      if (r) gidx = 0;
   endtask

   task automatic look();
      @(posedge clk); #1;
   endtask

   function automatic int sine_at(int idx);
      real offs[4] = '{0.0, 0.15, -0.1, 0.05};
      real t = real'(idx) + offs[idx % 4];
      return $rtoi(100.0 * $sin(2.0 * 3.14159265 * 0.073 * t));
   endfunction

   task automatic run_sine(int n, bit gaps);
      for (int i = 0; i < n; i++) begin
         if (gaps && ($urandom % 10) >= 6) cyc(0, 0, 8'h55);
         else begin cyc(0, 1, sine_at(gidx)); gidx++; end
      end
   endtask

   task automatic run_pat(int n, int a, int b, int c, int d);
      for (int i = 0; i < n; i++) begin
         case (gidx % 4)
            0: cyc(0, 1, a);
            1: cyc(0, 1, b);
            2: cyc(0, 1, c);
            default: cyc(0, 1, d);
         endcase
         gidx++;
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [47:0] held;
      rst = 1; in_valid = 0; in_sample = 0; freeze = 0; mu_shift = 4'd6;
      repeat (3) cyc(1, 0, 0);
      cyc(0, 0, 0); look();
      // R1: state after reset
      check(out_valid == 0, "R1", out_valid, 0);
      check(out_sample == 0, "R1", out_sample, 0);
      check(skew_bus == 0, "R1", skew_bus, 0);

      run_sine(300, 0);
      req_out = "R2"; run_sine(200, 1); req_out = "R4";

      cyc(0, 0, 0); look(); held = skew_bus;
      freeze = 1; req_sk = "R10";
      run_sine(80, 0);
      cyc(0, 0, 0); look();
      check(skew_bus == held, "R10", skew_bus, held);
      freeze = 0; req_sk = "R7"; mu_shift = 4'd1;
      run_sine(80, 0);
      req_sk = "R6"; mu_shift = 4'd4;

      // R1: reset in mid-stream realigns the rotation
      cyc(1, 1, 9); cyc(1, 0, 0); cyc(0, 0, 0); look();
      check(out_valid == 0, "R1", out_valid, 0);
      check(skew_bus == 0, "R1", skew_bus, 0);

      run_pat(200, 0, 127, 127, 0);
      cyc(0, 0, 0); look();
      check($signed(skew_bus[15:0]) == 32767, "R8", $signed(skew_bus[15:0]), 32767);
      check($signed(skew_bus[31:16]) == -32768, "R8", $signed(skew_bus[31:16]), -32768);
      check(skew_bus[47:32] == 0, "R11", skew_bus[47:32], 0);

      freeze = 1;
      run_pat(40, 0, 127, -128, 0);
      run_pat(40, 0, -128, 127, 0);
      repeat (4) cyc(0, 0, 0);
      look();
      check(clip_seen > 0, "R9", clip_seen, 1);
      freeze = 0;
      repeat (3) cyc(0, 0, 0);
      look();
      finish_run();
   end
endmodule